// File: doc/BRIEF.md
# Dual-Bank Operand Address Generator

This unit feeds a two-bank (X and Y) data memory in a processor that has been extended for signal processing. It holds eight pointers arranged as four X/Y pairs. Each pointer has its own step, region-start and region-size register. In any cycle the unit can serve up to three accesses: two operand reads (port A and port B) and one result write (port W). Each access names a pointer and a post-update mode. The unit returns the bank and the address for each access, and it advances the named pointers.

Both reads may land in the same bank. When they do, a flag is raised so that the bank serves the second read from its second read port. The write address is produced in the same cycle as the reads, so the datapath needs no arbitration for it. There are four update modes: unit increment, programmable signed step, step with wrap inside a circular region, and reverse-carry step for butterfly ordering in an FFT. Software loads the pointer state through a single configuration write port.

Top module: `xy_agu`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, every valid output and `rd_dual` are low. All pointer, step, start and size registers read as zero after reset.
- R2: An access enabled in cycle n raises its valid output in cycle n+1, and its address output carries the pointer value from before that access's own update. An access not enabled in cycle n leaves its valid output low in cycle n+1.
- R3: The select code has two parts. Its most significant bit picks the bank (0 = X, 1 = Y), and the lower bits pick the pair, so codes 0..3 are the X pointers and 4..7 are the Y pointers. The bank output repeats that most significant bit.
- R4: `rd_dual` is high in cycle n+1 exactly when both reads were enabled in cycle n and both selects named the same bank. This covers X with X and Y with Y.
- R5: Two reads through different pointers and one write through a third pointer are all served in the same cycle, each with its own correct address.
- R6: Mode 0 adds one to the pointer, modulo 2^AW.
- R7: Mode 1 adds the step register to the pointer, read as two's complement, modulo 2^AW.
- R8: Mode 2 adds the signed step. If the result reaches start+size or beyond, size is subtracted from it. If the result falls below start, size is added to it.
- R9: Mode 3 adds the step with the carry moving from the most significant bit toward the least significant bit. With a step of N/2 and a start value of 0, the pointer follows the bit-reversed order of 0..N-1.
- R10: When several accesses in one cycle name the same pointer, all of them see the old value. The pointer then takes the update from the highest-priority access among them, with W above B above A.
- R11: The configuration write selects a field with code 0 = pointer, 1 = step, 2 = start, 3 = size. If it targets a pointer that an access updates in the same cycle, the configuration value wins.
- R12: An access in the same cycle as a configuration write to its pointer returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_field | input | 2 | Field code: 0 pointer, 1 step, 2 start, 3 size |
| cfg_idx | input | IW | Pointer index to configure |
| cfg_data | input | AW | Configuration value |
| rd_a_en | input | 1 | Read port A request |
| rd_a_sel | input | IW | Read port A pointer select |
| rd_a_mode | input | 2 | Read port A update mode |
| rd_b_en | input | 1 | Read port B request |
| rd_b_sel | input | IW | Read port B pointer select |
| rd_b_mode | input | 2 | Read port B update mode |
| wr_en | input | 1 | Write port request |
| wr_sel | input | IW | Write port pointer select |
| wr_mode | input | 2 | Write port update mode |
| rd_a_vld | output | 1 | Port A address valid |
| rd_a_bank | output | 1 | Port A bank (0 X, 1 Y) |
| rd_a_addr | output | AW | Port A address |
| rd_b_vld | output | 1 | Port B address valid |
| rd_b_bank | output | 1 | Port B bank |
| rd_b_addr | output | AW | Port B address |
| rd_dual | output | 1 | Both reads hit one bank |
| wr_vld | output | 1 | Write address valid |
| wr_bank | output | 1 | Write bank |
| wr_addr | output | AW | Write address |

## Verification
The bench builds the unit with AW = 8 and the default four pairs. At that width, linear stepping crosses the 255-to-0 wrap in a few accesses, and an 8-point butterfly order runs through its full cycle and returns to zero. A small circular region of five words is exercised with steps in both directions, so that it wraps at the top and at the bottom. With eight pointers, the bench can drive X-with-X, Y-with-Y and mixed dual reads, plus cycles where all three ports and a configuration write name the same pointer.

// File: rtl/xy_agu_pkg.sv
package xy_agu_pkg;

    typedef enum logic [1:0] {
        MODE_LIN  = 2'd0,
        MODE_OFS  = 2'd1,
        MODE_CIRC = 2'd2,
        MODE_BREV = 2'd3
    } upd_mode_t;

    typedef enum logic [1:0] {
        FLD_PTR  = 2'd0,
        FLD_STEP = 2'd1,
        FLD_BASE = 2'd2,
        FLD_LEN  = 2'd3
    } cfg_field_t;

    localparam int unsigned NACC = 3;
    localparam int unsigned ACC_A = 0;
    localparam int unsigned ACC_B = 1;
    localparam int unsigned ACC_W = 2;

endpackage

// File: rtl/xy_agu_brev_add.sv
module xy_agu_brev_add #(
    parameter int unsigned W = 16
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y
);
    logic [W-1:0] ra;
    logic [W-1:0] rb;
    logic [W-1:0] rs;

    always_comb begin
        for (int i = 0; i < W; i++) begin
            ra[i] = a[W-1-i];
            rb[i] = b[W-1-i];
        end
        rs = ra + rb;
        for (int i = 0; i < W; i++) begin
            y[i] = rs[W-1-i];
        end
    end
endmodule

// File: rtl/xy_agu_step.sv
module xy_agu_step
    import xy_agu_pkg::*;
#(
    parameter int unsigned AW = 16
) (
    input  logic [AW-1:0] cur,
    input  logic [AW-1:0] step,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] len,
    input  logic [1:0]    mode,
    output logic [AW-1:0] nxt
);
    localparam int unsigned XW = AW + 2;

    logic [AW-1:0]        brev_sum;
    logic signed [XW-1:0] raw;
    logic signed [XW-1:0] lo;
    logic signed [XW-1:0] hi;
    logic signed [XW-1:0] sz;
    logic signed [XW-1:0] wrapped;

    xy_agu_brev_add #(.W(AW)) u_brev (
        .a (cur),
        .b (step),
        .y (brev_sum)
    );

    always_comb begin
        raw     = $signed({2'b00, cur}) + $signed({{2{step[AW-1]}}, step});
        lo      = $signed({2'b00, base});
        sz      = $signed({2'b00, len});
        hi      = lo + sz;
        wrapped = raw;
        if (raw >= hi) begin
            wrapped = raw - sz;
        end else if (raw < lo) begin
            wrapped = raw + sz;
        end

        unique case (upd_mode_t'(mode))
            MODE_LIN:  nxt = cur + AW'(1);
            MODE_OFS:  nxt = cur + step;
            MODE_CIRC: nxt = wrapped[AW-1:0];
            MODE_BREV: nxt = brev_sum;
            default:   nxt = cur;
        endcase
    end
endmodule

// File: rtl/xy_agu.sv
module xy_agu
    import xy_agu_pkg::*;
#(
    parameter int unsigned AW    = 16,
    parameter int unsigned NPAIR = 4,
    localparam int unsigned NPTR = 2 * NPAIR,
    localparam int unsigned IW   = $clog2(NPTR)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_field,
    input  logic [IW-1:0] cfg_idx,
    input  logic [AW-1:0] cfg_data,
    input  logic          rd_a_en,
    input  logic [IW-1:0] rd_a_sel,
    input  logic [1:0]    rd_a_mode,
    input  logic          rd_b_en,
    input  logic [IW-1:0] rd_b_sel,
    input  logic [1:0]    rd_b_mode,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_sel,
    input  logic [1:0]    wr_mode,
    output logic          rd_a_vld,
    output logic          rd_a_bank,
    output logic [AW-1:0] rd_a_addr,
    output logic          rd_b_vld,
    output logic          rd_b_bank,
    output logic [AW-1:0] rd_b_addr,
    output logic          rd_dual,
    output logic          wr_vld,
    output logic          wr_bank,
    output logic [AW-1:0] wr_addr
);
    typedef struct packed {
        logic [NPTR-1:0][AW-1:0] ptr;
        logic [NPTR-1:0][AW-1:0] step;
        logic [NPTR-1:0][AW-1:0] base;
        logic [NPTR-1:0][AW-1:0] len;
        logic [NACC-1:0]         vld;
        logic [NACC-1:0]         bank;
        logic [NACC-1:0][AW-1:0] addr;
        logic                    dual;
    } agu_state_t;

    agu_state_t st_d, st_q;

    logic [NACC-1:0]          acc_en;
    logic [NACC-1:0][IW-1:0]  acc_sel;
    logic [NACC-1:0][1:0]     acc_mode;
    logic [NACC-1:0][AW-1:0]  acc_cur;
    logic [NACC-1:0][AW-1:0]  acc_nxt;

    assign acc_en   = {wr_en, rd_b_en, rd_a_en};
    assign acc_sel  = {wr_sel, rd_b_sel, rd_a_sel};
    assign acc_mode = {wr_mode, rd_b_mode, rd_a_mode};

    for (genvar k = 0; k < NACC; k++) begin : g_acc
        assign acc_cur[k] = st_q.ptr[acc_sel[k]];
        xy_agu_step #(.AW(AW)) u_step (
            .cur  (acc_cur[k]),
            .step (st_q.step[acc_sel[k]]),
            .base (st_q.base[acc_sel[k]]),
            .len  (st_q.len[acc_sel[k]]),
            .mode (acc_mode[k]),
            .nxt  (acc_nxt[k])
        );
    end

    always_comb begin
        st_d = st_q;
        for (int k = 0; k < NACC; k++) begin
            st_d.vld[k] = acc_en[k];
            if (acc_en[k]) begin
                st_d.bank[k] = acc_sel[k][IW-1];
                st_d.addr[k] = acc_cur[k];
            end
        end
        st_d.dual = rd_a_en && rd_b_en && (rd_a_sel[IW-1] == rd_b_sel[IW-1]);

        // ascending order: later port overrides earlier on a shared pointer
        for (int k = 0; k < NACC; k++) begin
            if (acc_en[k]) begin
                st_d.ptr[acc_sel[k]] = acc_nxt[k];
            end
        end

        if (cfg_we) begin
            unique case (cfg_field_t'(cfg_field))
                FLD_PTR:  st_d.ptr[cfg_idx]  = cfg_data;
                FLD_STEP: st_d.step[cfg_idx] = cfg_data;
                FLD_BASE: st_d.base[cfg_idx] = cfg_data;
                FLD_LEN:  st_d.len[cfg_idx]  = cfg_data;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_a_vld  = st_q.vld[ACC_A];
    assign rd_a_bank = st_q.bank[ACC_A];
    assign rd_a_addr = st_q.addr[ACC_A];
    assign rd_b_vld  = st_q.vld[ACC_B];
    assign rd_b_bank = st_q.bank[ACC_B];
    assign rd_b_addr = st_q.addr[ACC_B];
    assign wr_vld    = st_q.vld[ACC_W];
    assign wr_bank   = st_q.bank[ACC_W];
    assign wr_addr   = st_q.addr[ACC_W];
    assign rd_dual   = st_q.dual;
endmodule

// File: rtl/xy_agu_chk.sv
module xy_agu_chk #(
    parameter int unsigned AW = 16,
    parameter int unsigned IW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          rd_a_en,
    input logic [IW-1:0] rd_a_sel,
    input logic          rd_b_en,
    input logic [IW-1:0] rd_b_sel,
    input logic          wr_en,
    input logic [IW-1:0] wr_sel,
    input logic          rd_a_vld,
    input logic          rd_a_bank,
    input logic [AW-1:0] rd_a_addr,
    input logic          rd_b_vld,
    input logic          rd_b_bank,
    input logic [AW-1:0] rd_b_addr,
    input logic          rd_dual,
    input logic          wr_vld,
    input logic          wr_bank,
    input logic [AW-1:0] wr_addr
);
    assert_a_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_en |=> rd_a_vld);
    assert_a_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_a_en |=> !rd_a_vld);
    assert_w_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> wr_vld);
    assert_a_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_a_en |=> (rd_a_bank == $past(rd_a_sel[IW-1])));
    assert_b_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_b_en |=> (rd_b_bank == $past(rd_b_sel[IW-1])));
    assert_w_bank_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_bank == $past(wr_sel[IW-1])));
    assert_dual_match_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_dual |-> (rd_a_vld && rd_b_vld && (rd_a_bank == rd_b_bank)));
    assert_shared_ptr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_en && rd_b_en && (rd_a_sel == rd_b_sel)) |=> (rd_a_addr == rd_b_addr));
    assert_shared_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_a_en && wr_en && (rd_a_sel == wr_sel)) |=> (rd_a_addr == wr_addr));
endmodule

bind xy_agu xy_agu_chk #(.AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_a_en   (rd_a_en),
    .rd_a_sel  (rd_a_sel),
    .rd_b_en   (rd_b_en),
    .rd_b_sel  (rd_b_sel),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .rd_a_vld  (rd_a_vld),
    .rd_a_bank (rd_a_bank),
    .rd_a_addr (rd_a_addr),
    .rd_b_vld  (rd_b_vld),
    .rd_b_bank (rd_b_bank),
    .rd_b_addr (rd_b_addr),
    .rd_dual   (rd_dual),
    .wr_vld    (wr_vld),
    .wr_bank   (wr_bank),
    .wr_addr   (wr_addr)
);

// File: tb/sim_xy_agu.sv
module sim_xy_agu;
    localparam int unsigned AW = 8;
    localparam int unsigned NPAIR = 4;
    localparam int unsigned IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_field = '0;
    logic [IW-1:0] cfg_idx = '0;
    logic [AW-1:0] cfg_data = '0;
    logic          rd_a_en = 1'b0;
    logic [IW-1:0] rd_a_sel = '0;
    logic [1:0]    rd_a_mode = '0;
    logic          rd_b_en = 1'b0;
    logic [IW-1:0] rd_b_sel = '0;
    logic [1:0]    rd_b_mode = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_sel = '0;
    logic [1:0]    wr_mode = '0;
    logic          rd_a_vld, rd_a_bank, rd_b_vld, rd_b_bank, rd_dual, wr_vld, wr_bank;
    logic [AW-1:0] rd_a_addr, rd_b_addr, wr_addr;

    int nchk = 0;
    int nfail = 0;

    always #5 clk = ~clk;

    xy_agu #(.AW(AW), .NPAIR(NPAIR)) u0 (
        .clk, .rst_n, .cfg_we, .cfg_field, .cfg_idx, .cfg_data,
        .rd_a_en, .rd_a_sel, .rd_a_mode, .rd_b_en, .rd_b_sel, .rd_b_mode,
        .wr_en, .wr_sel, .wr_mode,
        .rd_a_vld, .rd_a_bank, .rd_a_addr, .rd_b_vld, .rd_b_bank, .rd_b_addr,
        .rd_dual, .wr_vld, .wr_bank, .wr_addr
    );

    task automatic chk(input string tag, input int act, input int exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] f, input logic [IW-1:0] idx, input logic [AW-1:0] d);
        cfg_we = 1'b1; cfg_field = f; cfg_idx = idx; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic rda(input logic [IW-1:0] s, input logic [1:0] m,
                       output logic [AW-1:0] addr, output logic bank);
        rd_a_en = 1'b1; rd_a_sel = s; rd_a_mode = m;
        @(negedge clk);
        rd_a_en = 1'b0;
        addr = rd_a_addr;
        bank = rd_a_bank;
    endtask

    task automatic t_reset;
        logic [AW-1:0] a;
        logic bk;
        chk("R1 a_vld in reset", rd_a_vld, 0);
        chk("R1 dual in reset", rd_dual, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 a_vld after reset", rd_a_vld, 0);
        chk("R1 w_vld after reset", wr_vld, 0);
        rda(3'd6, 2'd0, a, bk);
        chk("R1 pointer zero", a, 0);
    endtask

    task automatic t_linear;
        logic [AW-1:0] a;
        logic bk;
        cfg(2'd0, 3'd1, 8'd254);
        for (int i = 0; i < 4; i++) begin
            rda(3'd1, 2'd0, a, bk);
            chk("R6 linear wrap", a, (254 + i) % 256);
            chk("R3 X bank", bk, 0);
        end
        chk("R2 vld after access", rd_a_vld, 1);
        @(negedge clk);
        chk("R2 vld idle", rd_a_vld, 0);
    endtask

    task automatic t_offset;
        logic [AW-1:0] a;
        logic bk;
        cfg(2'd0, 3'd5, 8'd10);
        cfg(2'd1, 3'd5, 8'hFD);
        for (int i = 0; i < 5; i++) begin
            rda(3'd5, 2'd1, a, bk);
            chk("R7 signed step", a, (10 - 3 * i + 256) % 256);
            chk("R3 Y bank", bk, 1);
        end
    endtask

    task automatic t_circ;
        logic [AW-1:0] a;
        logic bk;
        int p;
        cfg(2'd2, 3'd2, 8'd20);
        cfg(2'd3, 3'd2, 8'd5);
        cfg(2'd0, 3'd2, 8'd22);
        cfg(2'd1, 3'd2, 8'd2);
        p = 22;
        for (int i = 0; i < 7; i++) begin
            rda(3'd2, 2'd2, a, bk);
            chk("R8 circular up", a, p);
            p = p + 2;
            if (p >= 25) p = p - 5;
        end
        cfg(2'd0, 3'd2, 8'd21);
        cfg(2'd1, 3'd2, 8'hFE);
        p = 21;
        for (int i = 0; i < 7; i++) begin
            rda(3'd2, 2'd2, a, bk);
            chk("R8 circular down", a, p);
            p = p - 2;
            if (p < 20) p = p + 5;
        end
    endtask

    task automatic t_brev;
        logic [AW-1:0] a;
        logic bk;
        int order [9] = '{0, 4, 2, 6, 1, 5, 3, 7, 0};
        cfg(2'd0, 3'd3, 8'd0);
        cfg(2'd1, 3'd3, 8'd4);
        for (int i = 0; i < 9; i++) begin
            rda(3'd3, 2'd3, a, bk);
            chk("R9 bit reverse order", a, order[i]);
        end
    endtask

    task automatic t_dual;
        cfg(2'd0, 3'd0, 8'd100);
        cfg(2'd0, 3'd1, 8'd200);
        cfg(2'd0, 3'd4, 8'd50);
        cfg(2'd0, 3'd5, 8'd60);
        cfg(2'd0, 3'd6, 8'd77);
        rd_a_en = 1; rd_a_sel = 3'd0; rd_a_mode = 2'd0;
        rd_b_en = 1; rd_b_sel = 3'd1; rd_b_mode = 2'd0;
        @(negedge clk);
        chk("R5 A addr XX", rd_a_addr, 100);
        chk("R5 B addr XX", rd_b_addr, 200);
        chk("R4 dual XX", rd_dual, 1);
        rd_a_sel = 3'd0; rd_b_sel = 3'd4;
        wr_en = 1; wr_sel = 3'd6; wr_mode = 2'd0;
        @(negedge clk);
        chk("R5 A addr XY", rd_a_addr, 101);
        chk("R5 B addr XY", rd_b_addr, 50);
        chk("R5 W addr", wr_addr, 77);
        chk("R3 W bank", wr_bank, 1);
        chk("R3 B bank", rd_b_bank, 1);
        chk("R4 dual XY", rd_dual, 0);
        wr_en = 0;
        rd_a_sel = 3'd4; rd_b_sel = 3'd5;
        @(negedge clk);
        chk("R4 dual YY", rd_dual, 1);
        chk("R5 A addr YY", rd_a_addr, 51);
        chk("R5 B addr YY", rd_b_addr, 60);
        rd_a_en = 0; rd_b_en = 0;
        @(negedge clk);
        chk("R4 dual idle", rd_dual, 0);
    endtask

    task automatic t_shared;
        logic [AW-1:0] a;
        logic bk;
        cfg(2'd0, 3'd6, 8'd40);
        cfg(2'd1, 3'd6, 8'd10);
        rd_a_en = 1; rd_a_sel = 3'd6; rd_a_mode = 2'd0;
        rd_b_en = 1; rd_b_sel = 3'd6; rd_b_mode = 2'd0;
        wr_en = 1; wr_sel = 3'd6; wr_mode = 2'd1;
        @(negedge clk);
        wr_en = 0;
        chk("R10 A old value", rd_a_addr, 40);
        chk("R10 B old value", rd_b_addr, 40);
        chk("R10 W old value", wr_addr, 40);
        rd_a_mode = 2'd1; rd_b_mode = 2'd0;
        @(negedge clk);
        rd_a_en = 0; rd_b_en = 0;
        chk("R10 W update wins", rd_b_addr, 50);
        rda(3'd6, 2'd0, a, bk);
        chk("R10 B beats A", a, 51);
    endtask

    task automatic t_cfg_conflict;
        logic [AW-1:0] a;
        logic bk;
        cfg(2'd0, 3'd7, 8'd60);
        cfg_we = 1; cfg_field = 2'd0; cfg_idx = 3'd7; cfg_data = 8'd90;
        rd_a_en = 1; rd_a_sel = 3'd7; rd_a_mode = 2'd0;
        @(negedge clk);
        cfg_we = 0; rd_a_en = 0;
        chk("R12 read sees old value", rd_a_addr, 60);
        rda(3'd7, 2'd0, a, bk);
        chk("R11 config write wins", a, 90);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_linear();
        t_offset();
        t_circ();
        t_brev();
        t_dual();
        t_shared();
        t_cfg_conflict();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule